// File: doc/BRIEF.md
# MSI Doorbell to Wired Interrupt Bridge

This block sits on a simple 32-bit register bus and turns message-signalled interrupt writes into wired interrupt pulses for a downstream interrupt controller. It is built from a power-of-two number of frames. Each frame owns a 64 KB address window at its own base. Each frame also owns a window of interrupt numbers, given by a first number and a count. A device raises an interrupt by writing the interrupt number to a frame's doorbell register. When the number falls inside that frame's window, the bridge emits a one-cycle strobe carrying the number. When it does not, the write is dropped without any error.

Each frame exposes two read-only identification words. The type word packs the frame's first interrupt number and its count. The peripheral-ID word reports the total address footprint as a power of two of 4 KB blocks, derived from the frame count. Every request, including one that hits no frame, receives a response after a fixed, configurable number of cycles, so the bus can never hang. The frame count must be a power of two, every first interrupt number must be at least 32, and every window must fit inside the interrupt number width. The block refuses to elaborate with a configuration that breaks any of these rules.

Top module: `msi_bridge`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `irq_valid` and `rsp_ready` are low.
- R2: An address belongs to frame i when base_i <= address < base_i + 0x10000; when several windows contain the address, the frame with the lowest index is the one decoded.
- R3: A read at frame offset 0x008 returns the frame's first interrupt number in bits 31:16 and its interrupt count in bits 15:0.
- R4: A read at frame offset 0xFD0 returns 0x4 | ((4 + log2(NUM_FRAMES)) << 4), which is 0x64 for four frames.
- R5: A read at any other offset of a frame, or at an address outside every frame, returns zero.
- R6: A write of value m at frame offset 0x040 with first <= m < first + count drives `irq_valid` high for exactly one cycle, starting in the cycle after the accepting clock edge, with `irq_id` equal to the low 10 bits of m.
- R7: A doorbell write whose value is outside the decoded frame's window produces no strobe.
- R8: Writes to any offset other than 0x040, writes outside every frame, and all reads produce no strobe.
- R9: Every request is answered by `rsp_ready` high for one cycle, RESP_DELAY cycles after the accepting edge (visible after edge RESP_DELAY counted from the accepting edge as the first); for a write `rsp_rdata` is zero in that cycle.
- R10: Doorbell writes accepted on two consecutive edges produce two strobes on consecutive cycles, each carrying its own number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented in this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the word accessed |
| req_wdata | input | 32 | Write data; the doorbell value for a doorbell write |
| rsp_ready | output | 1 | Completion strobe for a request |
| rsp_rdata | output | 32 | Read data, valid while `rsp_ready` is high |
| irq_valid | output | 1 | One-cycle interrupt strobe |
| irq_id | output | IRQ_W | Interrupt number carried by the strobe |

## Verification
The doorbell strobe of one request and the delayed completion of an earlier request land in the same cycle whenever requests follow each other closely. The bench provokes this with two doorbell writes on consecutive edges: the second strobe appears in the same cycle as the first completion, and each is judged against numbers worked out from the frame configuration. Near-exhaustive sweeps of every frame's doorbell values across both window edges, plus reads of every identification word and of the overlapping and unmapped addresses, cover the decode and range logic.

// File: rtl/msi_bridge_pkg.sv
package msi_bridge_pkg;

    localparam int unsigned FRAME_SPAN = 32'h0001_0000;
    localparam int unsigned OFS_W      = 16;

    localparam logic [OFS_W-1:0] OFS_TYPE     = 16'h0008;
    localparam logic [OFS_W-1:0] OFS_DOORBELL = 16'h0040;
    localparam logic [OFS_W-1:0] OFS_PID4     = 16'h0FD0;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_TYPE,
        REG_DOORBELL,
        REG_PID4
    } reg_kind_t;

    typedef struct packed {
        logic        valid;
        logic        write;
        logic [31:0] wdata;
    } bus_cmd_t;

    function automatic reg_kind_t classify(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_TYPE:     return REG_TYPE;
            OFS_DOORBELL: return REG_DOORBELL;
            OFS_PID4:     return REG_PID4;
            default:      return REG_NONE;
        endcase
    endfunction

    function automatic logic [31:0] type_word(input logic [15:0] first,
                                              input logic [15:0] count);
        return {first, count};
    endfunction

    function automatic logic [31:0] pid4_word(input int unsigned log2_frames);
        return 32'h4 | (32'(4 + log2_frames) << 4);
    endfunction

    function automatic bit is_pow2(input int unsigned n);
        return (n != 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
    import msi_bridge_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IDX_W      = 2,
    parameter logic [NUM_FRAMES-1:0][ADDR_W-1:0] FRAME_BASE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [OFS_W-1:0]  ofs
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(FRAME_SPAN);

    logic [NUM_FRAMES-1:0]             in_win;
    logic [NUM_FRAMES-1:0][ADDR_W-1:0] rel;

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_win
        assign rel[f]    = addr - FRAME_BASE[f];
        assign in_win[f] = (addr >= FRAME_BASE[f]) && (rel[f] < SPAN);
    end

    // Walk from the top index down so the lowest matching frame is kept.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        ofs = '0;
        for (int f = NUM_FRAMES - 1; f >= 0; f--) begin
            if (in_win[f]) begin
                hit = 1'b1;
                idx = IDX_W'(f);
                ofs = rel[f][OFS_W-1:0];
            end
        end
    end

endmodule

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_bridge_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned IDX_W      = 2,
    parameter int unsigned IRQ_W      = 10,
    parameter logic [NUM_FRAMES-1:0][15:0] FRAME_FIRST = '0,
    parameter logic [NUM_FRAMES-1:0][15:0] FRAME_COUNT = '0
) (
    input  bus_cmd_t          cmd,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFS_W-1:0]  ofs,
    output logic [31:0]       rdata,
    output logic              ring,
    output logic [IRQ_W-1:0]  ring_id
);
    localparam int unsigned LOG2_FRAMES = $clog2(NUM_FRAMES);

    reg_kind_t   kind;
    logic [31:0] lo_bound;
    logic [31:0] hi_bound;
    logic        in_range;

    always_comb begin
        kind     = classify(ofs);
        lo_bound = {16'b0, FRAME_FIRST[idx]};
        hi_bound = lo_bound + {16'b0, FRAME_COUNT[idx]};
        in_range = (cmd.wdata >= lo_bound) && (cmd.wdata < hi_bound);
    end

    always_comb begin
        rdata = '0;
        if (cmd.valid && !cmd.write && hit) begin
            case (kind)
                REG_TYPE: rdata = type_word(FRAME_FIRST[idx], FRAME_COUNT[idx]);
                REG_PID4: rdata = pid4_word(LOG2_FRAMES);
                default:  rdata = '0;
            endcase
        end
    end

    assign ring    = cmd.valid && cmd.write && hit && (kind == REG_DOORBELL) && in_range;
    assign ring_id = cmd.wdata[IRQ_W-1:0];

endmodule

// File: rtl/msi_resp_pipe.sv
module msi_resp_pipe #(
    parameter int unsigned DEPTH  = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DEPTH:0]             stg_v;
    logic [DEPTH:0][DATA_W-1:0] stg_d;

    assign stg_v[0] = in_valid;
    assign stg_d[0] = in_data;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_v[s+1] <= 1'b0;
                stg_d[s+1] <= '0;
            end else begin
                stg_v[s+1] <= stg_v[s];
                stg_d[s+1] <= stg_v[s] ? stg_d[s] : '0;
            end
        end
    end

    assign out_valid = stg_v[DEPTH];
    assign out_data  = stg_d[DEPTH];

endmodule

// File: rtl/msi_bridge.sv
module msi_bridge
    import msi_bridge_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IRQ_W      = 10,
    parameter int unsigned RESP_DELAY = 2,
    parameter logic [NUM_FRAMES-1:0][ADDR_W-1:0] FRAME_BASE =
        {32'h0FFF_8000, 32'h2000_0000, 32'h1001_0000, 32'h1000_0000},
    parameter logic [NUM_FRAMES-1:0][15:0] FRAME_FIRST =
        {16'd300, 16'd200, 16'd100, 16'd64},
    parameter logic [NUM_FRAMES-1:0][15:0] FRAME_COUNT =
        {16'd32, 16'd4, 16'd8, 16'd16}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    output logic              irq_valid,
    output logic [IRQ_W-1:0]  irq_id
);
    localparam int unsigned IDX_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
    localparam int unsigned IRQ_TOP = 1 << IRQ_W;

    // Configuration legality, checked when the design is elaborated.
    if (!is_pow2(NUM_FRAMES)) begin : g_bad_count
        $error("msi_bridge: NUM_FRAMES must be a power of two");
    end
    if (RESP_DELAY < 1) begin : g_bad_delay
        $error("msi_bridge: RESP_DELAY must be at least one");
    end
    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_cfg
        if (FRAME_FIRST[f] < 16'd32) begin : g_bad_first
            $error("msi_bridge: frame first interrupt below 32");
        end
        if (32'(FRAME_FIRST[f]) + 32'(FRAME_COUNT[f]) > IRQ_TOP) begin : g_bad_span
            $error("msi_bridge: frame interrupt window exceeds IRQ_W");
        end
    end

    bus_cmd_t           cmd;
    logic               hit;
    logic [IDX_W-1:0]   idx;
    logic [OFS_W-1:0]   ofs;
    logic [31:0]        rdata;
    logic               ring;
    logic [IRQ_W-1:0]   ring_id;

    assign cmd = '{valid: req_valid, write: req_write, wdata: req_wdata};

    msi_frame_decode #(
        .NUM_FRAMES (NUM_FRAMES),
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .FRAME_BASE (FRAME_BASE)
    ) u_decode (
        .addr (req_addr),
        .hit  (hit),
        .idx  (idx),
        .ofs  (ofs)
    );

    msi_reg_decode #(
        .NUM_FRAMES  (NUM_FRAMES),
        .IDX_W       (IDX_W),
        .IRQ_W       (IRQ_W),
        .FRAME_FIRST (FRAME_FIRST),
        .FRAME_COUNT (FRAME_COUNT)
    ) u_regs (
        .cmd     (cmd),
        .hit     (hit),
        .idx     (idx),
        .ofs     (ofs),
        .rdata   (rdata),
        .ring    (ring),
        .ring_id (ring_id)
    );

    msi_resp_pipe #(
        .DEPTH  (RESP_DELAY),
        .DATA_W (32)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_data   (rdata),
        .out_valid (rsp_ready),
        .out_data  (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid <= 1'b0;
            irq_id    <= '0;
        end else begin
            irq_valid <= ring;
            if (ring) begin
                irq_id <= ring_id;
            end
        end
    end

endmodule

// File: rtl/msi_bridge_chk.sv
module msi_bridge_chk #(
    parameter int unsigned NUM_FRAMES = 4,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IRQ_W      = 10,
    parameter int unsigned RESP_DELAY = 2,
    parameter logic [NUM_FRAMES-1:0][15:0] FRAME_FIRST = '0,
    parameter logic [NUM_FRAMES-1:0][15:0] FRAME_COUNT = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_ready,
    input logic [31:0]       rsp_rdata,
    input logic              irq_valid,
    input logic [IRQ_W-1:0]  irq_id
);
    logic [RESP_DELAY-1:0] seen_req;
    logic [RESP_DELAY-1:0] seen_wr;
    logic                  id_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_req <= '0;
            seen_wr  <= '0;
        end else begin
            seen_req <= (seen_req << 1) | RESP_DELAY'(req_valid);
            seen_wr  <= (seen_wr << 1)  | RESP_DELAY'(req_valid && req_write);
        end
    end

    always_comb begin
        id_ok = 1'b0;
        for (int f = 0; f < NUM_FRAMES; f++) begin
            if (32'(irq_id) >= 32'(FRAME_FIRST[f]) &&
                32'(irq_id) <  32'(FRAME_FIRST[f]) + 32'(FRAME_COUNT[f])) begin
                id_ok = 1'b1;
            end
        end
    end

    // R8: a strobe can only follow a write request.
    a_r8_strobe_needs_write: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> $past(req_valid && req_write));

    // R7: a strobe never carries a number outside every frame window.
    a_r7_id_in_window: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> id_ok);

    // R9: completion appears exactly RESP_DELAY edges after the request.
    a_r9_ready_delay: assert property (@(posedge clk) disable iff (rst)
        rsp_ready == seen_req[RESP_DELAY-1]);

    // R9: a completed write carries zero data.
    a_r9_write_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_ready && seen_wr[RESP_DELAY-1]) |-> (rsp_rdata == 32'h0));

    // R1: outputs are quiet in the cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!irq_valid && !rsp_ready));

endmodule

bind msi_bridge msi_bridge_chk #(
    .NUM_FRAMES  (NUM_FRAMES),
    .ADDR_W      (ADDR_W),
    .IRQ_W       (IRQ_W),
    .RESP_DELAY  (RESP_DELAY),
    .FRAME_FIRST (FRAME_FIRST),
    .FRAME_COUNT (FRAME_COUNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .irq_valid (irq_valid),
    .irq_id    (irq_id)
);

// File: tb/tb_msi_bridge.sv
module tb_msi_bridge;
    localparam int unsigned NF = 4;
    localparam int unsigned D  = 2;
    localparam logic [NF-1:0][31:0] BASES  =
        {32'h0FFF_8000, 32'h2000_0000, 32'h1001_0000, 32'h1000_0000};
    localparam logic [NF-1:0][15:0] FIRSTS = {16'd300, 16'd200, 16'd100, 16'd64};
    localparam logic [NF-1:0][15:0] COUNTS = {16'd32, 16'd4, 16'd8, 16'd16};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic        irq_valid;
    logic [9:0]  irq_id;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    msi_bridge #(
        .NUM_FRAMES (NF), .ADDR_W (32), .IRQ_W (10), .RESP_DELAY (D),
        .FRAME_BASE (BASES), .FRAME_FIRST (FIRSTS), .FRAME_COUNT (COUNTS)
    ) dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .rsp_ready (rsp_ready),
        .rsp_rdata (rsp_rdata), .irq_valid (irq_valid), .irq_id (irq_id)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_frame(input logic [31:0] a);
        for (int f = 0; f < NF; f++) begin
            if (a >= BASES[f] && (a - BASES[f]) < 32'h1_0000) return f;
        end
        return -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [31:0] a);
        int f = model_frame(a);
        logic [31:0] o;
        if (f < 0) return 32'h0;
        o = a - BASES[f];
        if (o == 32'h008) return (32'(FIRSTS[f]) << 16) | 32'(COUNTS[f]);
        if (o == 32'hFD0) return 32'h4 | ((4 + $clog2(NF)) << 4);
        return 32'h0;
    endfunction

    function automatic bit model_ring(input logic [31:0] a, input logic [31:0] m);
        int f = model_frame(a);
        if (f < 0) return 1'b0;
        if ((a - BASES[f]) != 32'h040) return 1'b0;
        return (m >= 32'(FIRSTS[f])) && (m < 32'(FIRSTS[f]) + 32'(COUNTS[f]));
    endfunction

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d, input string req);
        bit          strb;
        bit          exp_s;
        logic [9:0]  id;
        int          lat;
        logic [31:0] er;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        strb = irq_valid; id = irq_id; lat = 1;
        while (!rsp_ready && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        check(lat == D, "R9 response latency", lat, D);
        if (wr) begin
            check(rsp_rdata == 32'h0, "R9 write data zero", rsp_rdata, 0);
        end else begin
            er = model_read(a);
            check(rsp_rdata == er, req, rsp_rdata, er);
        end
        exp_s = wr && model_ring(a, d);
        check(strb == exp_s, wr ? {req, " strobe"} : "R8 read gives no strobe", strb, exp_s);
        if (exp_s) begin
            check(id == d[9:0], "R6 irq id", id, d[9:0]);
            check(irq_valid == 1'b0, "R6 strobe lasts one cycle", irq_valid, 0);
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(irq_valid == 1'b0, "R1 irq_valid in reset", irq_valid, 0);
        check(rsp_ready == 1'b0, "R1 rsp_ready in reset", rsp_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        check(irq_valid == 1'b0 && rsp_ready == 1'b0, "R1 quiet after reset",
              {irq_valid, rsp_ready}, 0);

        // R3 and R4: identification words of every frame
        for (int f = 0; f < NF; f++) begin
            access(1'b0, BASES[f] + 32'h008, 0, "R3 type word");
            access(1'b0, BASES[f] + 32'hFD0, 0, "R4 peripheral-ID word");
        end

        // R5: other offsets and unmapped addresses read zero
        access(1'b0, BASES[1] + 32'h000, 0, "R5 other offset");
        access(1'b0, BASES[1] + 32'h004, 0, "R5 other offset");
        access(1'b0, BASES[1] + 32'h040, 0, "R5 doorbell reads zero");
        access(1'b0, BASES[2] + 32'hFFFC, 0, "R5 last word");
        access(1'b0, 32'h0000_0000, 0, "R5 unmapped");
        access(1'b0, 32'h3000_0008, 0, "R5 unmapped");

        // R2: window edges and lowest-index priority on overlap
        access(1'b0, BASES[3] - 32'h4 + 32'h008 - 32'h008, 0, "R2 below lowest base");
        access(1'b0, BASES[0] + 32'h1_0008, 0, "R2 next window");
        access(1'b0, 32'h1000_0008, 0, "R2 overlap decodes frame 0");
        access(1'b1, 32'h1000_0040, 32'd300, "R2 overlap doorbell to frame 0");
        access(1'b1, 32'h1000_0040, 32'd64, "R2 overlap doorbell frame 0 in range");

        // R6 and R7: sweep every frame's doorbell across both window edges
        for (int f = 0; f < NF; f++) begin
            for (int m = int'(FIRSTS[f]) - 2; m <= int'(FIRSTS[f]) + int'(COUNTS[f]) + 1; m++) begin
                access(1'b1, BASES[f] + 32'h040, 32'(m),
                       model_ring(BASES[f] + 32'h040, 32'(m)) ? "R6 in-range doorbell"
                                                              : "R7 out-of-range doorbell");
            end
        end
        access(1'b1, BASES[0] + 32'h040, 32'h8000_0040, "R7 high bits set");

        // R8: writes elsewhere are ignored
        access(1'b1, BASES[0] + 32'h008, 32'd64, "R8 write to type");
        access(1'b1, BASES[0] + 32'hFD0, 32'd64, "R8 write to peripheral-ID");
        access(1'b1, BASES[0] + 32'h044, 32'd64, "R8 write next to doorbell");
        access(1'b1, 32'h3000_0040, 32'd64, "R8 unmapped write");
        access(1'b0, BASES[0] + 32'h008, 0, "R8 type unchanged after write");

        // R10: back-to-back doorbells, strobe coincides with first completion
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = BASES[0] + 32'h040; req_wdata = 32'd70;
        @(negedge clk);
        check(irq_valid == 1'b1 && irq_id == 10'd70, "R10 first strobe", irq_id, 70);
        req_addr = BASES[1] + 32'h040; req_wdata = 32'd105;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check(irq_valid == 1'b1 && irq_id == 10'd105, "R10 second strobe", irq_id, 105);
        check(rsp_ready == 1'b1, "R9 first completion with second strobe", rsp_ready, 1);
        @(negedge clk);
        check(irq_valid == 1'b0, "R10 strobes end", irq_valid, 0);
        check(rsp_ready == 1'b1 && rsp_rdata == 32'h0, "R9 second completion", rsp_ready, 1);
        @(negedge clk);
        check(rsp_ready == 1'b0, "R9 single completion each", rsp_ready, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule